// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer with an 8-bit up-counter and an 8-bit control/status register, both reached over a minimal register bus. The design accepts a write only when the upper byte of the write data carries the key that belongs to the addressed register. A write with any other upper byte changes nothing. The counter key is 0x5A and the control/status key is 0xA5, so one stray store cannot reload or reconfigure the timer.

A 3-bit clock-select code divides the input clock by a power of two before that clock advances the counter. When the counter wraps, the block raises a sticky status flag and drives a one-clock overflow pulse. Software services the watchdog by reloading the counter before it wraps. A keyed reload also restarts the prescaler, so the next overflow always comes one full interval after the reload. The base division is a parameter. The default of 5 gives ratios from 1/32 up to 1/4096.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 0 whose upper byte (bits BUS_W-1 down to BUS_W-8) equals 0x5A loads bits 7:0 of the write data into the counter at that clock edge.
- R2: A write to address 1 whose upper byte equals 0xA5 updates the control/status register. Data bits 2:0 give the clock-select code and data bit 5 gives the enable bit.
- R3: A write whose upper byte is not the addressed register's key leaves the counter, the control/status register and the prescaler phase unchanged.
- R4: Reads need no key and are combinational from the address. Address 0 returns the counter. Address 1 returns {flag, 0, enable, 0, 0, select[2:0]}, with the flag in bit 7.
- R5: After reset the counter reads 0x00 and the control/status register reads 0x00 (select code 0, disabled, flag clear).
- R6: With select code c, the counter advances once every 2^(BASE_LOG2+c) clocks. After a reload to value v, the overflow pulse rises (256-v)*2^(BASE_LOG2+c) clocks after the reload edge.
- R7: While the enable bit is 0, the counter and the prescaler hold their values.
- R8: When the counter wraps from 0xFF to 0x00, the overflow output is high for exactly one clock, the counter reads 0x00 during that clock, and the flag reads 1 from that same clock onward.
- R9: A keyed control/status write with data bit 7 equal to 0 clears the flag. With data bit 7 equal to 1 the flag keeps its current value, so software cannot set it.
- R10: A keyed counter write restarts the prescaler from zero, so the interval to the next overflow does not depend on the prescaler phase at the reload.
- R11: With BUS_W = 32 the key is taken from bits 31:24. A key placed in any other byte lane is not recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| reg_addr | input | 1 | 0 selects the counter, 1 selects the control/status register |
| wr_data | input | BUS_W | Key in the upper byte, value in the low byte |
| rd_data | output | 8 | Readback of the addressed register |
| ovf_pulse | output | 1 | One-clock pulse on each counter wrap |

## Verification
The main instance uses BASE_LOG2 = 0, so the clock-select codes give ratios from 1 to 128. This keeps an overflow interval for every one of the eight codes short enough to measure exactly, to the clock, from the reload edge. A full 256-step period is also measured. Phase-sensitive cases, a reload or a wrong-key write in the middle of a prescaler interval, give cycle counts that differ visibly between correct and incorrect handling. A second instance with BUS_W = 32 checks that the key is taken from the top byte lane only.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int BYTE_W  = 8;
    localparam int CSEL_W  = 3;
    localparam logic [BYTE_W-1:0] CNT_KEY = 8'h5A;
    localparam logic [BYTE_W-1:0] CSR_KEY = 8'hA5;

    typedef enum logic {
        REG_CNT = 1'b0,
        REG_CSR = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              flag;
        logic              en;
        logic [CSEL_W-1:0] csel;
    } csr_t;

    typedef struct packed {
        logic              cnt_ld;
        logic              csr_ld;
        logic [BYTE_W-1:0] val;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] csr_image(csr_t c);
        return {c.flag, 1'b0, c.en, 2'b00, c.csel};
    endfunction
endpackage

// File: rtl/wdt_keycheck.sv
module wdt_keycheck
    import wdt_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [BUS_W-1:0] wr_data,
    output wr_req_t          req
);
    localparam int KEY_LSB = BUS_W - BYTE_W;

    logic [BYTE_W-1:0] key_byte;
    reg_sel_e          target;

    always_comb begin
        key_byte   = wr_data[BUS_W-1:KEY_LSB];
        target     = reg_sel_e'(reg_addr);
        req.val    = wr_data[BYTE_W-1:0];
        req.cnt_ld = wr_en && (target == REG_CNT) && (key_byte == CNT_KEY);
        req.csr_ld = wr_en && (target == REG_CSR) && (key_byte == CSR_KEY);
    end

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.cnt_ld, req.csr_ld}));
    // R3
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !(req.cnt_ld || req.csr_ld));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic [CSEL_W-1:0] csel,
    output logic              tick
);
    localparam int PRE_W = BASE_LOG2 + (1 << CSEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = (PRE_W'(1) << (BASE_LOG2 + int'(csel))) - PRE_W'(1);
        tick = en && !restart && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
        end else if (en) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R7
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> en);
    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_val,
    input  logic              tick,
    output logic [BYTE_W-1:0] cnt,
    output logic              wrap_evt,
    output logic              wrap_q
);
    assign wrap_evt = tick && !ld && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= wrap_evt;
            if (ld) begin
                cnt <= ld_val;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (cnt == '0));
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);
    // R1
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cnt == $past(ld_val)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && !tick) |=> $stable(cnt));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic [7:0]       rd_data,
    output logic             ovf_pulse
);
    wr_req_t           req;
    csr_t              csr_q;
    logic              tick;
    logic              wrap_evt;
    logic [BYTE_W-1:0] cnt;

    wdt_keycheck #(.BUS_W(BUS_W)) u_key (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .req      (req)
    );

    wdt_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (csr_q.en),
        .restart (req.cnt_ld),
        .csel    (csr_q.csel),
        .tick    (tick)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ld       (req.cnt_ld),
        .ld_val   (req.val),
        .tick     (tick),
        .cnt      (cnt),
        .wrap_evt (wrap_evt),
        .wrap_q   (ovf_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
        end else begin
            if (req.csr_ld) begin
                csr_q.csel <= req.val[CSEL_W-1:0];
                csr_q.en   <= req.val[5];
                csr_q.flag <= (csr_q.flag && req.val[7]) || wrap_evt;
            end else if (wrap_evt) begin
                csr_q.flag <= 1'b1;
            end
        end
    end

    always_comb begin
        if (reg_sel_e'(reg_addr) == REG_CSR) begin
            rd_data = csr_image(csr_q);
        end else begin
            rd_data = cnt;
        end
    end

    // R8
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> csr_q.flag);
    // R3
    csr_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.csr_ld && !wrap_evt) |=> $stable(csr_q));
    // R9
    flag_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!csr_q.flag && !wrap_evt) |=> !csr_q.flag);
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        ovf_pulse;

    logic        w_wr_en = 1'b0;
    logic        w_addr = 1'b0;
    logic [31:0] w_data = '0;
    logic [7:0]  w_rd;
    logic        w_ovf;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    keyed_wdt #(.BUS_W(16), .BASE_LOG2(0)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .ovf_pulse(ovf_pulse)
    );

    keyed_wdt #(.BUS_W(32), .BASE_LOG2(0)) dut_w (
        .clk(clk), .rst(rst), .wr_en(w_wr_en), .reg_addr(w_addr),
        .wr_data(w_data), .rd_data(w_rd), .ovf_pulse(w_ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr_w(input logic a, input logic [31:0] d);
        w_wr_en = 1'b1; w_addr = a; w_data = d;
        @(posedge clk);
        @(negedge clk);
        w_wr_en = 1'b0; w_data = '0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_ovf(output int n);
        n = 0;
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (ovf_pulse) break;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int n;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state
        rd(0, v); check("R5 counter after reset", v, 0);
        rd(1, v); check("R5 csr after reset", v, 0);

        // R1 keyed load of every value pattern (timer disabled)
        for (int d = 0; d < 256; d += 17) begin
            wr(0, 16'h5A00 | 16'(d));
            rd(0, v); check("R1 counter load", v, d);
        end

        // R3 wrong keys to the counter, including the other register's key
        wr(0, 16'hA533); rd(0, v); check("R3 counter csr-key ignored", v, 255);
        wr(0, 16'h5B33); rd(0, v); check("R3 counter bad key ignored", v, 255);
        wr(0, 16'h0033); rd(0, v); check("R3 counter zero key ignored", v, 255);

        // R2 / R4 csr write and readback format
        wr(1, 16'hA5FF); rd(1, v); check("R2 R4 csr readback masks", v, 8'h27);
        wr(1, 16'hA503); rd(1, v); check("R2 csr disabled code 3", v, 8'h03);
        // R3 wrong key to csr
        wr(1, 16'h5A25); rd(1, v); check("R3 csr cnt-key ignored", v, 8'h03);
        wr(1, 16'hA425); rd(1, v); check("R3 csr bad key ignored", v, 8'h03);

        // R7 disabled timer holds
        wr(0, 16'h5AF0);
        idle(300);
        rd(0, v); check("R7 counter holds while disabled", v, 8'hF0);
        check("R7 no overflow while disabled", int'(ovf_pulse), 0);

        // R6 sweep all select codes: 16 steps from 0xF0
        for (int c = 0; c < 8; c++) begin
            wr(1, 16'hA520 | 16'(c));
            wr(0, 16'h5AF0);
            wait_ovf(n);
            check($sformatf("R6 interval code %0d", c), n, 16 << c);
            rd(0, v); check("R8 counter zero in pulse", v, 0);
            rd(1, v); check("R8 flag set in pulse", v & 8'h80, 8'h80);
            idle(1);
            check("R8 pulse one clock", int'(ovf_pulse), 0);
            // R9 writing 1 keeps flag, writing 0 clears it
            wr(1, 16'hA5A0 | 16'(c));
            rd(1, v); check("R9 flag kept on write 1", v, 8'hA0 | c);
            wr(1, 16'hA520 | 16'(c));
            rd(1, v); check("R9 flag cleared on write 0", v, 8'h20 | c);
        end

        // R6 full period from 0x00 at code 2
        wr(1, 16'hA522);
        wr(0, 16'h5A00);
        wait_ovf(n);
        check("R6 full period code 2", n, 1024);

        // R10 reload mid-interval restarts prescaler (code 3, ratio 8)
        wr(1, 16'hA523);
        wr(0, 16'h5AFE);
        idle(4);
        wr(0, 16'h5AFE);
        wait_ovf(n);
        check("R10 reload restarts prescaler", n, 16);

        // R3 wrong-key write mid-interval leaves prescaler phase
        wr(0, 16'h5AFE);
        idle(4);
        wr(0, 16'h5BFE);
        wait_ovf(n);
        check("R3 prescaler untouched by bad key", n, 11);

        // R11 32-bit form key lane
        wr_w(0, 32'h5A00_0033);
        w_addr = 1'b0; #1;
        check("R11 32-bit key in top byte", int'(w_rd), 8'h33);
        wr_w(0, 32'h005A_0044);
        w_addr = 1'b0; #1;
        check("R11 key in other lane ignored", int'(w_rd), 8'h33);
        wr_w(1, 32'hA500_0025);
        w_addr = 1'b1; #1;
        check("R11 32-bit csr key", int'(w_rd), 8'h25);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule